// File: doc/BRIEF.md
# Chainable Debug Test Access Port with Single-Bit Bypass

This block is one serial test access port for one core. Several copies are strung in series: the serial output of one feeds the serial input of the next. All copies share the test clock and the mode-select line, so every copy walks through the same sixteen controller states in lockstep. Each port holds an instruction. Any nonzero instruction selects a wide data register. That register is captured from the core's register file at the start of a data scan and written back to the core at the end of it. The instruction value doubles as the register address.

The all-zero instruction puts the port in bypass. A single bit then sits between serial input and serial output, and the core sees no access. Reset loads the all-zero instruction. A port whose serial input is tied to constant 0 therefore parks itself during every instruction scan, and contributes only one bit of delay to data scans through the chain.

Top module: `chain_tap_port`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the controller enters Test-Logic-Reset. `active_op` becomes 8'h00, `core_wr` becomes 0, and `tdo` and `tdo_en` are 0 after the next falling edge.
- R2: From any state, five rising edges with `tms` high place the controller in Test-Logic-Reset. `active_op` reads 8'h00 after one further rising edge in that state.
- R3: During Shift-IR the bits leaving on `tdo` are the capture pattern 8'h01, least significant bit first: one 1, then seven 0s.
- R4: Instruction bits enter from `tdi` least significant bit first. `active_op` keeps its old value through the whole instruction scan, including the Update-IR state. It takes the shifted value on the rising edge that leaves Update-IR.
- R5: With a nonzero `active_op`, Capture-DR loads `core_rdata`. Shift-DR then presents that value on `tdo` least significant bit first. A bit entering on `tdi` reappears on `tdo` 32 shift cycles later.
- R6: With a nonzero `active_op`, the rising edge that leaves Update-DR sets `core_wdata` to the last 32 bits shifted in (the most recent bit at bit 31) and raises `core_wr` for exactly one `tck` cycle.
- R7: With `active_op` equal to 8'h00, Shift-DR passes through one bypass bit that is captured as 0. The first `tdo` bit is 0, and each later `tdo` bit equals the `tdi` bit of the previous shift cycle.
- R8: A data scan with `active_op` equal to 8'h00 never raises `core_wr` and leaves `core_wdata` unchanged.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 exactly in the half-cycles that follow a Shift-IR or Shift-DR state, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock shared by every port in the chain |
| trst_n | input | 1 | Synchronous active-low reset, sampled on rising `tck` |
| tms | input | 1 | Mode select shared by every port, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| core_rdata | input | 32 | Read data from the core register addressed by `active_op` |
| active_op | output | 8 | Current instruction; 8'h00 means bypass, any other value is a register address |
| core_wdata | output | 32 | Write data presented to the core after Update-DR |
| core_wr | output | 1 | One-cycle write strobe for `core_wdata` at address `active_op` |

## Verification
The bench builds the port with its default widths: an 8-bit instruction and a 32-bit data register. With an 8-bit instruction the sweep can visit all 256 opcodes, each with a full instruction scan and a full data scan. The bypass opcode and every register address are therefore both covered, with capture data and write data computed from the opcode value. Longer 40-bit data scans on a few opcodes expose the exact 32-cycle and 1-cycle serial delays. A closing sequence enters Test-Logic-Reset from the middle of a data scan using only `tms`.

// File: rtl/ctap_pkg.sv
// Package: shared controller state type and next-state rule for the
// chainable test access port. Assumes the sixteen-state controller of
// the IEEE 1149.1 style, advanced by TMS on each rising test clock.
package ctap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    // Next controller state for a given present state and TMS level.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ctap_ctrl.sv
// Module: test access port controller. Holds the sixteen-state
// sequence and steps it once per rising test clock from TMS.
// Assumes a synchronous active-low reset sampled on that same edge.
module ctap_ctrl
    import ctap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    // Advance the controller state, or force Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

    // Five sampled TMS-high edges always end in Test-Logic-Reset.
    AST_TMS_FIVE_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == ST_RESET)); // R2

endmodule

// File: rtl/ctap_scan_stage.sv
// Module: one serial scan register with a separate parallel hold stage.
// Capture loads the shift stage, shift moves it one place toward bit 0
// with the new bit entering at the top, update copies it to the hold
// stage. Assumes the three controls are never high together.
module ctap_scan_stage #(
    parameter int          WIDTH    = 8,
    parameter logic [WIDTH-1:0] HOLD_INIT = '0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] capture_val,
    input  logic             shift,
    input  logic             serial_in,
    input  logic             update,
    input  logic             hold_clear,
    output logic             serial_out,
    output logic [WIDTH-1:0] hold
);

    logic [WIDTH-1:0] stage_q;

    // Shift stage: capture a parallel value or move one bit per cycle.
    always_ff @(posedge tck) begin
        if (!trst_n)      stage_q <= '0;
        else if (capture) stage_q <= capture_val;
        else if (shift)   stage_q <= {serial_in, stage_q[WIDTH-1:1]};
    end

    // Hold stage: changes only on update or an explicit clear.
    always_ff @(posedge tck) begin
        if (!trst_n || hold_clear) hold <= HOLD_INIT;
        else if (update)           hold <= stage_q;
    end

    assign serial_out = stage_q[0];

endmodule

// File: rtl/ctap_out_stage.sv
// Module: serial output launcher. Picks the bit at the end of the
// active scan path and registers it on the falling test clock, with an
// enable that marks valid shift data. Assumes the shift states come
// from the rising-edge controller.
module ctap_out_stage (
    input  logic tck,
    input  logic trst_n,
    input  logic in_sh_ir,
    input  logic in_sh_dr,
    input  logic use_data_reg,
    input  logic ir_bit,
    input  logic dr_bit,
    input  logic bypass_bit,
    output logic tdo,
    output logic tdo_en
);

    logic next_bit;

    // Select the bit at the end of whichever path is being shifted.
    always_comb begin
        if (in_sh_ir)          next_bit = ir_bit;
        else if (in_sh_dr)     next_bit = use_data_reg ? dr_bit : bypass_bit;
        else                   next_bit = 1'b0;
    end

    // Launch on the falling edge so the next port samples half a cycle later.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= next_bit;
            tdo_en <= in_sh_ir || in_sh_dr;
        end
    end

endmodule

// File: rtl/chain_tap_port.sv
// Module: chainable debug test access port. An instruction register
// selects either a single bypass bit (all-zero opcode) or a data
// register tied to a core register file, where the opcode is the
// register address. Assumes TCK and TMS are shared by every port of
// the chain, so all ports follow the same state sequence.
module chain_tap_port
    import ctap_pkg::*;
#(
    parameter int IR_W = 8,
    parameter int DR_W = 32
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    input  logic [DR_W-1:0] core_rdata,
    output logic [IR_W-1:0] active_op,
    output logic [DR_W-1:0] core_wdata,
    output logic            core_wr
);

    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [IR_W-1:0] OP_BYPASS  = '0;

    tap_state_e state;
    logic       sel_data;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       bypass_q;

    ctap_ctrl u_ctrl (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    assign sel_data = (active_op != OP_BYPASS);

    ctap_scan_stage #(.WIDTH(IR_W), .HOLD_INIT(OP_BYPASS)) u_ir (
        .tck         (tck),
        .trst_n      (trst_n),
        .capture     (state == ST_CAP_IR),
        .capture_val (IR_CAPTURE),
        .shift       (state == ST_SH_IR),
        .serial_in   (tdi),
        .update      (state == ST_UPD_IR),
        .hold_clear  (state == ST_RESET),
        .serial_out  (ir_lsb),
        .hold        (active_op)
    );

    ctap_scan_stage #(.WIDTH(DR_W), .HOLD_INIT('0)) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .capture     ((state == ST_CAP_DR) && sel_data),
        .capture_val (core_rdata),
        .shift       ((state == ST_SH_DR) && sel_data),
        .serial_in   (tdi),
        .update      ((state == ST_UPD_DR) && sel_data),
        .hold_clear  (1'b0),
        .serial_out  (dr_lsb),
        .hold        (core_wdata)
    );

    // Bypass bit: cleared on capture, one-bit delay line while shifting.
    always_ff @(posedge tck) begin
        if (!trst_n)                  bypass_q <= 1'b0;
        else if (state == ST_CAP_DR)  bypass_q <= 1'b0;
        else if (state == ST_SH_DR)   bypass_q <= tdi;
    end

    // Write strobe: one cycle after leaving Update-DR on a register opcode.
    always_ff @(posedge tck) begin
        if (!trst_n) core_wr <= 1'b0;
        else         core_wr <= (state == ST_UPD_DR) && sel_data;
    end

    ctap_out_stage u_out (
        .tck          (tck),
        .trst_n       (trst_n),
        .in_sh_ir     (state == ST_SH_IR),
        .in_sh_dr     (state == ST_SH_DR),
        .use_data_reg (sel_data),
        .ir_bit       (ir_lsb),
        .dr_bit       (dr_lsb),
        .bypass_bit   (bypass_q),
        .tdo          (tdo),
        .tdo_en       (tdo_en)
    );

    // The write strobe never lasts longer than one cycle.
    AST_WR_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
        core_wr |=> !core_wr); // R6

    // A write never happens while the bypass opcode is active.
    AST_WR_NOT_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
        core_wr |-> (active_op != OP_BYPASS)); // R8

    // The instruction only moves on Update-IR or in Test-Logic-Reset.
    AST_OP_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(active_op)); // R4

    // Outside shifting the serial output is quiet.
    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo); // R9

    // Write data holds still unless a write strobe follows.
    AST_WDATA_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        !core_wr |-> $stable(core_wdata) || $past(state) == ST_UPD_DR); // R8

endmodule

// File: tb/tb_chain_tap_port.sv
`timescale 1ns/1ps
module tb_chain_tap_port;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        tdo_en;
    logic [31:0] core_rdata;
    logic [7:0]  active_op;
    logic [31:0] core_wdata;
    logic        core_wr;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    logic [31:0] last_w = '0;

    always #2 tck = ~tck;

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        return {a, ~a, a ^ 8'hA5, 8'h3C ^ {a[3:0], a[7:4]}};
    endfunction

    function automatic logic [31:0] wr_model(input logic [7:0] a);
        return {~a, a, a ^ 8'h96, a + 8'd7};
    endfunction

    assign core_rdata = rd_model(active_op);

    chain_tap_port dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_en(tdo_en), .core_rdata(core_rdata), .active_op(active_op),
        .core_wdata(core_wdata), .core_wr(core_wr)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK cycle: drive after the falling edge, sample serial output,
    // then confirm nothing moved on the rising edge (R9).
    task automatic step(input logic m, input logic d, output logic so, output logic en);
        @(negedge tck); #1;
        tms = m; tdi = d;
        so = tdo; en = tdo_en;
        @(posedge tck); #1;
        chk(tdo == so && tdo_en == en, "R9 rising-edge stability", {tdo_en, tdo}, {en, so});
    endtask

    task automatic ir_scan(input logic [7:0] op, input logic [7:0] prev);
        logic so, en;
        logic [7:0] cap;
        step(1, 0, so, en);
        chk(!en && !so, "R9 idle quiet", {en, so}, 0);
        step(1, 0, so, en);
        step(0, 0, so, en);
        step(0, 0, so, en);
        for (int k = 0; k < 8; k++) begin
            step(k == 7, op[k], so, en);
            cap[k] = so;
            chk(en, "R9 enable in Shift-IR", en, 1);
        end
        chk(cap == 8'h01, "R3 capture pattern", cap, 8'h01);
        chk(active_op == prev, "R4 held during shift", active_op, prev);
        step(1, 0, so, en);
        chk(active_op == prev, "R4 held in Update-IR", active_op, prev);
        step(0, 0, so, en);
        chk(active_op == op, "R4 loaded after Update-IR", active_op, op);
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din, input logic [7:0] op);
        logic so, en;
        logic [63:0] dout = '0;
        logic [63:0] exp_out = '0;
        logic [31:0] exp_w;
        step(1, 0, so, en);
        step(0, 0, so, en);
        step(0, 0, so, en);
        for (int k = 0; k < n; k++) begin
            step(k == n - 1, din[k], so, en);
            dout[k] = so;
            chk(en, "R9 enable in Shift-DR", en, 1);
        end
        for (int k = 0; k < n; k++) begin
            if (op != 0) exp_out[k] = (k < 32) ? rd_model(op)[k] : din[k-32];
            else         exp_out[k] = (k == 0) ? 1'b0 : din[k-1];
        end
        if (op != 0) chk(dout == exp_out, "R5 capture and 32-cycle delay", dout, exp_out);
        else         chk(dout == exp_out, "R7 single bypass bit", dout, exp_out);
        exp_w = din[n-1 -: 32];
        step(1, 0, so, en);
        chk(core_wr == 0, "R6 no strobe before Update-DR exits", core_wr, 0);
        step(0, 0, so, en);
        if (op != 0) begin
            chk(core_wr == 1, "R6 strobe", core_wr, 1);
            chk(core_wdata == exp_w, "R6 write data", core_wdata, exp_w);
            last_w = exp_w;
        end else begin
            chk(core_wr == 0, "R8 no strobe in bypass", core_wr, 0);
            chk(core_wdata == last_w, "R8 write data untouched", core_wdata, last_w);
        end
        step(0, 0, so, en);
        chk(core_wr == 0, "R6 strobe one cycle", core_wr, 0);
    endtask

    initial begin
        logic so, en;
        logic [7:0] prev;
        repeat (3) @(posedge tck);
        #1;
        chk(active_op == 0, "R1 opcode reset", active_op, 0);
        chk(core_wr == 0, "R1 strobe reset", core_wr, 0);
        @(negedge tck); #1;
        chk(tdo == 0 && tdo_en == 0, "R1 serial output reset", {tdo_en, tdo}, 0);
        trst_n = 1'b1;
        step(0, 0, so, en);
        prev = 8'h00;
        for (int op = 0; op < 256; op++) begin
            ir_scan(8'(op), prev);
            dr_scan(32, {32'h0, wr_model(8'(op))}, 8'(op));
            prev = 8'(op);
        end
        // Longer scans expose the exact serial delay of each path.
        ir_scan(8'h3C, prev);
        dr_scan(40, 64'h00_A7C3_5E19_66, 8'h3C);
        ir_scan(8'h00, 8'h3C);
        dr_scan(40, 64'h00_91_2B4D_E6F0, 8'h00);
        // R2: leave the middle of a data scan with TMS alone.
        ir_scan(8'h5A, 8'h00);
        step(1, 0, so, en);
        step(0, 0, so, en);
        step(0, 0, so, en);
        for (int k = 0; k < 5; k++) step(1, 0, so, en);
        chk(active_op == 8'h5A, "R2 opcode before reset state acts", active_op, 8'h5A);
        step(1, 0, so, en);
        chk(active_op == 8'h00, "R2 reset by TMS", active_op, 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule